// File: doc/BRIEF.md
# PCI Configuration Address Translator

This block sits between a local-bus master and a host bridge that turns a window of local address space into PCI configuration transactions. The master hands it one configuration request: bus number, device slot, function, register offset, direction, access size and write data. The block builds the local address that reaches the right configuration register, together with the 16-bit mapping value the bridge needs for that access. It then steps the bridge through a fixed sequence: load the mapping value, open the configuration window, perform one access, close the window.

A request for bus zero produces a Type 0 cycle. The device is selected by a single set bit whose position follows the slot number. When that bit falls in the top byte of the address, it is carried in the mapping value instead. A request for any other bus produces a Type 1 cycle, with bus, device and function packed into the address. Type 1 writes follow a fixed workaround path and are sent to the window base address. The block accepts one request at a time. It ends each request with a one-cycle completion pulse, which carries an error flag and, for reads, the data moved down to the low bits.

Top module: `pci_cfg_xlate`

## Requirements
- R1: After reset, `busy`, `done`, `err`, `map_we`, `win_open` and `cyc_valid` are all low. A request is taken only when `req_valid` is high and `busy` is low. `busy` stays high from the cycle after acceptance through the `done` cycle. A `req_valid` raised while `busy` is high has no effect.
- R2: For bus 0, `cyc_addr` is built from four parts combined: WIN_HI in bits 31:24, a single one at bit (slot+11) when that position is below 24, the function in bits 10:8, and offset bits 7:2 in bits 7:2. Bits 1:0 are 00.
- R3: For bus 0, `map_data` is 0x000A. When slot+11 is 24 or higher, the device bit is also set in `map_data` at position (slot+11−16), so it lands in bits 15:8.
- R4: For a non-zero bus read, `cyc_addr` holds WIN_HI in bits 31:24, the bus in 23:16, the 5-bit slot in 15:11, the function in 10:8, offset bits 7:2 in 7:2, and 00 in 1:0.
- R5: For a non-zero bus, `map_data` is 0x000B.
- R6: The timing, with acceptance at clock edge k, is as follows. `map_we` is high for exactly one cycle, after edge k. `win_open` is high alone for the next cycle. `cyc_valid` and `win_open` are then high together until a cycle in which `cyc_ack` is high. In the following cycle `win_open` is low and `done` pulses. With an acknowledge after L wait cycles, `done` is seen 4+L cycles after `req_valid` is driven.
- R7: A write to a non-zero bus drives `cyc_addr` = {WIN_HI, 24'h0}, whatever the slot, function and offset.
- R8: A request is rejected if it targets bus 0 with slot above 20, or if it has size code 3. A rejected request raises `done` and `err` together in the cycle after acceptance and produces no `map_we`, `win_open` or `cyc_valid`.
- R9: Size codes are 0 for byte, 1 for 16 bits and 2 for 32 bits. `cyc_be` is 0001 shifted left by offset[1:0] for a byte, 1100 or 0011 by offset[1] for 16 bits, and 1111 for 32 bits. `cyc_wdata` places the write data in those same lanes.
- R10: At `done` after a read, `rdata` holds the acknowledged data. For a byte read it is the lane chosen by offset[1:0], and for a 16-bit read the half chosen by offset[1]; in both cases the data is moved to the low bits and zero-extended.
- R11: `err` is low at the `done` of every accepted, valid request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bus | input | 8 | Target bus number |
| req_slot | input | 5 | Device slot |
| req_func | input | 3 | Function number |
| req_reg | input | 8 | Register byte offset |
| req_size | input | 2 | 0 byte, 1 16-bit, 2 32-bit, 3 invalid |
| req_wdata | input | 32 | Write data, low-aligned |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Request rejected, valid with done |
| rdata | output | 32 | Low-aligned read data |
| map_we | output | 1 | Load mapping value into the bridge |
| map_data | output | 16 | Mapping value |
| win_open | output | 1 | Configuration window open |
| cyc_valid | output | 1 | Configuration access strobe |
| cyc_write | output | 1 | Access direction |
| cyc_addr | output | 32 | Local address of the access |
| cyc_be | output | 4 | Byte enables |
| cyc_wdata | output | 32 | Lane-placed write data |
| cyc_ack | input | 1 | Access complete |
| cyc_rdata | input | 32 | Read data from the bridge |

## Verification
The assertions assume that `cyc_ack` arrives only while `cyc_valid` is high and that the bridge eventually acknowledges every access. The bench responder raises the acknowledge after a chosen number of wait cycles and lowers it as soon as the strobe drops. The request fields are assumed to be meaningful only in the cycle of acceptance. The bench drives them for a single cycle, and it raises a second request on purpose while the block is busy, to show that the request is ignored.

// File: rtl/pci_cfg_xlate.sv
module pci_cfg_xlate #(
  parameter logic [7:0] WIN_HI  = 8'h40,
  parameter int         DEV_LSB = 11
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic [7:0]  req_bus,
  input  logic [4:0]  req_slot,
  input  logic [2:0]  req_func,
  input  logic [7:0]  req_reg,
  input  logic [1:0]  req_size,
  input  logic [31:0] req_wdata,
  output logic        busy,
  output logic        done,
  output logic        err,
  output logic [31:0] rdata,
  output logic        map_we,
  output logic [15:0] map_data,
  output logic        win_open,
  output logic        cyc_valid,
  output logic        cyc_write,
  output logic [31:0] cyc_addr,
  output logic [3:0]  cyc_be,
  output logic [31:0] cyc_wdata,
  input  logic        cyc_ack,
  input  logic [31:0] cyc_rdata
);

  localparam int MAX_SLOT = 31 - DEV_LSB;

  typedef enum logic [2:0] {S_IDLE, S_MAP, S_OPEN, S_CYC, S_CLOSE, S_FAULT} state_t;
  state_t state;

  logic        q_write;
  logic [7:0]  q_bus;
  logic [4:0]  q_slot;
  logic [2:0]  q_func;
  logic [7:0]  q_reg;
  logic [1:0]  q_size;
  logic [31:0] q_wdata;

  logic        far_bus;
  logic [5:0]  dev_pos;
  logic [31:0] dev_bit;
  logic [31:0] near_addr;
  logic [31:0] far_addr;
  logic        bad_req;
  logic [31:0] lane_rd;

  assign bad_req = ((req_bus == 8'd0) && (int'(req_slot) > MAX_SLOT)) || (req_size == 2'b11);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      q_write <= 1'b0;
      q_bus   <= '0;
      q_slot  <= '0;
      q_func  <= '0;
      q_reg   <= '0;
      q_size  <= '0;
      q_wdata <= '0;
      rdata   <= '0;
    end else begin
      case (state)
        S_IDLE:
          if (req_valid) begin
            q_write <= req_write;
            q_bus   <= req_bus;
            q_slot  <= req_slot;
            q_func  <= req_func;
            q_reg   <= req_reg;
            q_size  <= req_size;
            q_wdata <= req_wdata;
            state   <= bad_req ? S_FAULT : S_MAP;
          end
        S_MAP:  state <= S_OPEN;
        S_OPEN: state <= S_CYC;
        S_CYC:
          if (cyc_ack) begin
            if (!q_write) rdata <= lane_rd;
            state <= S_CLOSE;
          end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy      = (state != S_IDLE);
  assign done      = (state == S_CLOSE) || (state == S_FAULT);
  assign err       = (state == S_FAULT);
  assign map_we    = (state == S_MAP);
  assign win_open  = (state == S_OPEN) || (state == S_CYC);
  assign cyc_valid = (state == S_CYC);
  assign cyc_write = q_write;

  assign far_bus   = (q_bus != 8'd0);
  assign dev_pos   = {1'b0, q_slot} + 6'(DEV_LSB);
  assign dev_bit   = (dev_pos < 6'd32) ? (32'd1 << dev_pos[4:0]) : 32'd0;
  assign near_addr = {WIN_HI, 24'h0} | (dev_bit & 32'h00FF_FFFF) |
                     {21'd0, q_func, q_reg[7:2], 2'b00};
  assign far_addr  = {WIN_HI, q_bus, q_slot, q_func, q_reg[7:2], 2'b00};

  assign cyc_addr  = !far_bus ? near_addr : (q_write ? {WIN_HI, 24'h0} : far_addr);
  assign map_data  = far_bus ? 16'h000B : (16'h000A | {dev_bit[31:24], 8'h00});

  always_comb begin
    case (q_size)
      2'd0: begin
        cyc_be    = 4'b0001 << q_reg[1:0];
        cyc_wdata = {24'd0, q_wdata[7:0]} << {q_reg[1:0], 3'b000};
        lane_rd   = {24'd0, 8'(cyc_rdata >> {q_reg[1:0], 3'b000})};
      end
      2'd1: begin
        cyc_be    = q_reg[1] ? 4'b1100 : 4'b0011;
        cyc_wdata = q_reg[1] ? {q_wdata[15:0], 16'd0} : {16'd0, q_wdata[15:0]};
        lane_rd   = {16'd0, q_reg[1] ? cyc_rdata[31:16] : cyc_rdata[15:0]};
      end
      default: begin
        cyc_be    = 4'b1111;
        cyc_wdata = q_wdata;
        lane_rd   = cyc_rdata;
      end
    endcase
  end

  assert_idle_after_done_R1: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
  assert_done_implies_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);
  assert_addr_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_valid && !cyc_ack) |=> (cyc_valid && $stable(cyc_addr) && $stable(cyc_be)));
  assert_map_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
    map_we |-> (($countones(map_data[15:8]) <= 1) && (map_data[3:1] == 3'b101)));
  assert_map_before_open_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(win_open) |-> $past(map_we));
  assert_cyc_inside_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_valid |-> win_open);
  assert_done_window_shut_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!win_open && !cyc_valid && !map_we));
  assert_reject_no_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (done && !$past(win_open) && !$past(map_we)));

endmodule

// File: tb/tb_pci_cfg_xlate.sv
`timescale 1ns/1ps
module tb_pci_cfg_xlate;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [7:0]  req_bus = '0, req_reg = '0;
  logic [4:0]  req_slot = '0;
  logic [2:0]  req_func = '0;
  logic [1:0]  req_size = '0;
  logic [31:0] req_wdata = '0;
  logic        busy, done, err, map_we, win_open, cyc_valid, cyc_write;
  logic [31:0] rdata, cyc_addr, cyc_wdata;
  logic [15:0] map_data;
  logic [3:0]  cyc_be;
  logic        cyc_ack = 1'b0;
  logic [31:0] cyc_rdata = '0;

  localparam logic [31:0] RD_PAT = 32'hA1B2_C3D4;

  pci_cfg_xlate dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_bus(req_bus), .req_slot(req_slot), .req_func(req_func), .req_reg(req_reg),
    .req_size(req_size), .req_wdata(req_wdata), .busy(busy), .done(done), .err(err),
    .rdata(rdata), .map_we(map_we), .map_data(map_data), .win_open(win_open),
    .cyc_valid(cyc_valid), .cyc_write(cyc_write), .cyc_addr(cyc_addr), .cyc_be(cyc_be),
    .cyc_wdata(cyc_wdata), .cyc_ack(cyc_ack), .cyc_rdata(cyc_rdata)
  );

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0;
  bit finished = 0;

  int          lat = 0, wait_cnt = 0;
  int          map_cnt, open_cnt, cyc_cnt, stray_cnt;
  logic [15:0] cap_map;
  logic [31:0] cap_addr, cap_wdata;
  logic [3:0]  cap_be;
  int          done_at;
  logic        got_err;
  logic [31:0] got_rdata;

  always @(negedge clk) begin
    if (map_we) begin map_cnt++; cap_map = map_data; end
    if (win_open) open_cnt++;
    if (cyc_valid && !win_open) stray_cnt++;
    if (cyc_valid) begin
      cyc_cnt++;
      cap_addr = cyc_addr; cap_be = cyc_be; cap_wdata = cyc_wdata;
      if (!cyc_ack && wait_cnt == lat) begin
        cyc_ack = 1'b1; cyc_rdata = RD_PAT;
      end else if (!cyc_ack) begin
        wait_cnt++;
      end
    end else begin
      cyc_ack = 1'b0; wait_cnt = 0; cyc_rdata = '0;
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic run(input logic wr, input logic [7:0] bus, input logic [4:0] slot,
                     input logic [2:0] fn, input logic [7:0] rg, input logic [1:0] sz,
                     input logic [31:0] wd, input int l, input bit inject);
    map_cnt = 0; open_cnt = 0; cyc_cnt = 0; stray_cnt = 0;
    cap_map = 'x; cap_addr = 'x; cap_be = 'x; cap_wdata = 'x;
    done_at = -1; got_err = 1'b0; got_rdata = 'x; lat = l;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_bus = bus; req_slot = slot;
    req_func = fn; req_reg = rg; req_size = sz; req_wdata = wd;
    for (int i = 1; i <= 40; i++) begin
      @(negedge clk);
      if (i == 1) req_valid = 1'b0;
      if (inject && i == 2) begin
        req_valid = 1'b1; req_write = 1'b0; req_bus = 8'd0; req_slot = 5'd7;
        req_size = 2'd2; req_reg = 8'h20;
      end
      if (inject && i == 3) req_valid = 1'b0;
      if (done) begin
        done_at = i; got_err = err; got_rdata = rdata;
        break;
      end
    end
    @(negedge clk);
  endtask

  function automatic logic [31:0] near_exp(logic [4:0] s, logic [2:0] f, logic [7:0] r);
    logic [31:0] a = 32'h4000_0000 | (32'(f) << 8) | (32'(r) & 32'hFC);
    if (int'(s) + 11 < 24) a |= (32'd1 << (int'(s) + 11));
    return a;
  endfunction

  task automatic t_reset;
    check("R1 busy at reset", busy, 0);
    check("R1 done at reset", done, 0);
    check("R1 outputs quiet", {map_we, win_open, cyc_valid, err}, 4'b0);
  endtask

  task automatic t_near_long;
    run(0, 8'd0, 5'd3, 3'd2, 8'h10, 2'd2, 0, 0, 0);
    check("R2 type0 addr", cap_addr, near_exp(5'd3, 3'd2, 8'h10));
    check("R3 type0 map", cap_map, 16'h000A);
    check("R6 done timing", done_at, 4);
    check("R6 one map write", map_cnt, 1);
    check("R6 window cycles", open_cnt, 2);
    check("R6 cyc inside window", stray_cnt, 0);
    check("R9 long be", cap_be, 4'hF);
    check("R10 long read", got_rdata, RD_PAT);
    check("R11 no err", got_err, 0);
    check("R1 idle after", busy, 0);
  endtask

  task automatic t_near_spill_byte;
    run(0, 8'd0, 5'd13, 3'd0, 8'h06, 2'd0, 0, 0, 0);
    check("R2 spill addr", cap_addr, 32'h4000_0004);
    check("R3 spill map bit24", cap_map, 16'h010A);
    check("R9 byte be", cap_be, 4'b0100);
    check("R10 byte lane", got_rdata, 32'h0000_00B2);
  endtask

  task automatic t_near_top_word;
    run(0, 8'd0, 5'd20, 3'd1, 8'h0A, 2'd1, 0, 3, 0);
    check("R2 top addr", cap_addr, 32'h4000_0108);
    check("R3 top map bit31", cap_map, 16'h800A);
    check("R6 wait timing", done_at, 7);
    check("R9 word be", cap_be, 4'b1100);
    check("R10 word half", got_rdata, 32'h0000_A1B2);
    check("R11 no err", got_err, 0);
  endtask

  task automatic t_near_low_slot;
    run(0, 8'd0, 5'd12, 3'd0, 8'h00, 2'd0, 0, 1, 0);
    check("R2 slot12 addr", cap_addr, 32'h4080_0000);
    check("R3 slot12 map", cap_map, 16'h000A);
    check("R10 byte lane0", got_rdata, 32'h0000_00D4);
  endtask

  task automatic t_far_read;
    run(0, 8'd5, 5'd31, 3'd7, 8'hFE, 2'd1, 0, 0, 0);
    check("R4 type1 addr", cap_addr, 32'h4005_FFFC);
    check("R5 type1 map", cap_map, 16'h000B);
    check("R10 far word", got_rdata, 32'h0000_A1B2);
    check("R11 far no err", got_err, 0);
  endtask

  task automatic t_far_write;
    run(1, 8'd2, 5'd9, 3'd3, 8'h43, 2'd0, 32'h0000_005A, 0, 0);
    check("R7 far write base", cap_addr, 32'h4000_0000);
    check("R5 far write map", cap_map, 16'h000B);
    check("R9 byte be lane3", cap_be, 4'b1000);
    check("R9 byte wdata lane3", cap_wdata, 32'h5A00_0000);
  endtask

  task automatic t_near_write;
    run(1, 8'd0, 5'd1, 3'd0, 8'h02, 2'd1, 32'h0000_1234, 0, 0);
    check("R2 type0 write addr", cap_addr, 32'h4000_1000);
    check("R9 word be", cap_be, 4'b1100);
    check("R9 word wdata", cap_wdata, 32'h1234_0000);
  endtask

  task automatic t_reject;
    run(0, 8'd0, 5'd21, 3'd0, 8'h00, 2'd2, 0, 0, 0);
    check("R8 bad slot err", got_err, 1);
    check("R8 bad slot timing", done_at, 1);
    check("R8 bad slot no activity", map_cnt + open_cnt + cyc_cnt, 0);
    run(0, 8'd4, 5'd0, 3'd0, 8'h00, 2'd3, 0, 0, 0);
    check("R8 bad size err", got_err, 1);
    check("R8 bad size no activity", map_cnt + open_cnt + cyc_cnt, 0);
    run(0, 8'd3, 5'd25, 3'd0, 8'h00, 2'd2, 0, 0, 0);
    check("R8 high slot on far bus ok", got_err, 0);
    check("R4 far slot25 addr", cap_addr, 32'h4003_C800);
  endtask

  task automatic t_busy_ignore;
    run(0, 8'd0, 5'd2, 3'd0, 8'h08, 2'd2, 0, 2, 1);
    check("R1 ignored map writes", map_cnt, 1);
    check("R1 addr of first req", cap_addr, near_exp(5'd2, 3'd0, 8'h08));
    check("R1 done timing", done_at, 6);
    repeat (3) @(negedge clk);
    check("R1 no second request", busy, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_near_long();
    t_near_spill_byte();
    t_near_top_word();
    t_near_low_slot();
    t_far_read();
    t_far_write();
    t_near_write();
    t_reject();
    t_busy_ignore();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule